// File: doc/BRIEF.md
# Serial Flash Read Window

This block presents an attached serial flash as a read-only region of the host address map. A single-cycle read strobe whose address falls in the window is turned into one serial read transaction. The transaction sends a one-byte read opcode and a 24-bit byte address taken from the low offset bits, then clocks in four data bytes. The host side stalls on `bus_ready` until the word is back.

The flash holds words least-significant byte first. The four received bytes are reordered so that the byte at the lowest flash address lands in the least significant lane of `bus_rdata`. This swap is fixed and only exists on this read path. Data seen by the separate register-driven command engine passes straight through untouched.

Both this block and the command engine need the serial pins. An internal arbiter therefore hands them to one owner at a time. A transaction that has started always runs to completion before the other side gets the pins. Any write strobe is refused with a one-cycle error and leaves the flash alone, and so is any read outside the window.

Top module: `flash_alias_window`

## Requirements
- R1: While reset is held, `bus_ready`=1, `bus_err`=0, `spi_cs_n`=1, `spi_sck`=0, `spi_mosi`=0 and `eng_gnt`=0.
- R2: A read is in the window when `bus_addr[31:27]`=5'b00001 (0x0800_0000 to 0x0FFF_FFFF). A read outside it raises `bus_err` for the one cycle after the strobe, keeps `bus_ready` high and produces no `spi_sck` pulse.
- R3: A write strobe to any address raises `bus_err` for the one cycle after the strobe, keeps `bus_ready` high and produces no `spi_sck` pulse.
- R4: An accepted read drives `spi_cs_n` low and sends 32 bits MSB first on `spi_mosi`, each valid at a rising `spi_sck`. The bits are opcode 8'h03 followed by `bus_addr[23:0]`.
- R5: Each accepted read gives exactly 64 rising `spi_sck` edges while `spi_cs_n` is low: 32 send bits, then 32 receive bits sampled MSB first. `spi_sck` idles low.
- R6: If b0..b3 are the received bytes in arrival order, the word returned is `bus_rdata` = {b3,b2,b1,b0}.
- R7: `bus_ready` is low from the cycle after an accepted read until the cycle in which the swapped word appears on `bus_rdata`. `bus_rdata` then holds until the next accepted read completes, and refused accesses leave it unchanged.
- R8: `eng_gnt` rises one cycle after `eng_req` when no read transaction is pending. While `eng_gnt` is high, `spi_sck`, `spi_cs_n` and `spi_mosi` follow `eng_sck`, `eng_cs_n` and `eng_mosi`. When `eng_req` drops, the pins return to idle.
- R9: A read accepted while the engine holds the pins produces no `spi_sck` activity until `eng_req` drops. An `eng_req` raised during a read transaction gets no `eng_gnt` until that transaction has completed.
- R10: When a pending window read and `eng_req` compete in the same cycle with the pins free, the engine is granted first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | One-cycle access strobe |
| bus_write | input | 1 | Access is a write |
| bus_addr | input | 32 | Host byte address |
| bus_ready | output | 1 | Low while a window read is outstanding |
| bus_rdata | output | 32 | Byte-swapped read word |
| bus_err | output | 1 | One-cycle error for refused accesses |
| eng_req | input | 1 | Command engine wants the serial pins |
| eng_gnt | output | 1 | Command engine owns the serial pins |
| eng_sck | input | 1 | Engine serial clock |
| eng_cs_n | input | 1 | Engine chip select |
| eng_mosi | input | 1 | Engine serial data out |
| spi_sck | output | 1 | Serial clock to flash |
| spi_cs_n | output | 1 | Chip select to flash |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The properties assume that the host raises `bus_valid` for one cycle only and only while `bus_ready` is high. They also assume that the engine keeps `eng_req` high for its whole transaction. The bench's access task holds the strobe for exactly one cycle and issues it only after `bus_ready` has returned high. The engine is modelled by driving `eng_req` as a level that is held across the checks made while it owns the pins. A flash model in the bench answers from a computed byte pattern, so each returned word can be predicted from its address alone.

// File: rtl/flash_alias_pkg.sv
package flash_alias_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_ENG   = 2'd1,
        OWN_ALIAS = 2'd2
    } owner_e;
endpackage

// File: rtl/flash_alias_decode.sv
module flash_alias_decode #(
    parameter int          ADDR_W    = 32,
    parameter int          WIN_TAG_W = 5,
    parameter logic [4:0]  WIN_TAG   = 5'h01,
    parameter int          FLASH_AW  = 24
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                write,
    output logic                rd_hit,
    output logic [FLASH_AW-1:0] flash_addr
);
    localparam int OFF_W = ADDR_W - WIN_TAG_W;

    // window offset is folded onto the flash byte address range
    assign rd_hit     = (addr[ADDR_W-1 -: WIN_TAG_W] == WIN_TAG[WIN_TAG_W-1:0]) && !write;
    assign flash_addr = FLASH_AW'(addr[OFF_W-1:0]);
endmodule

// File: rtl/flash_alias_arb.sv
module flash_alias_arb
    import flash_alias_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   eng_req,
    input  logic   alias_req,
    input  logic   alias_done,
    output owner_e owner
);
    owner_e own_d, own_q;

    always_comb begin
        own_d = own_q;
        case (own_q)
            OWN_NONE: begin
                // engine wins a tie
                if (eng_req)        own_d = OWN_ENG;
                else if (alias_req) own_d = OWN_ALIAS;
            end
            OWN_ENG:   if (!eng_req)   own_d = OWN_NONE;
            OWN_ALIAS: if (alias_done) own_d = OWN_NONE;
            default:                   own_d = OWN_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) own_q <= OWN_NONE;
        else        own_q <= own_d;
    end

    assign owner = own_q;
endmodule

// File: rtl/flash_alias_shift.sv
module flash_alias_shift #(
    parameter int CMD_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              miso,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx
);
    localparam int TOTAL = CMD_W + DATA_W;
    localparam int CNT_W = $clog2(TOTAL);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(TOTAL - 1);
    localparam logic [CNT_W-1:0] RX_FROM = CNT_W'(CMD_W);

    typedef struct packed {
        logic              busy;
        logic              phase;
        logic [CNT_W-1:0]  cnt;
        logic [CMD_W-1:0]  tx;
        logic [DATA_W-1:0] rx;
        logic              done;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy  = 1'b1;
                d.phase = 1'b0;
                d.cnt   = '0;
                d.tx    = cmd;
            end
        end else if (!q.phase) begin
            d.phase = 1'b1;
        end else begin
            // end of high half: sample, then advance on the falling edge
            d.phase = 1'b0;
            if (q.cnt >= RX_FROM) d.rx = {q.rx[DATA_W-2:0], miso};
            d.tx = {q.tx[CMD_W-2:0], 1'b0};
            if (q.cnt == LAST) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck  = q.busy & q.phase;
    assign cs_n = ~q.busy;
    assign mosi = q.busy & q.tx[CMD_W-1];
    assign busy = q.busy;
    assign done = q.done;
    assign rx   = q.rx;
endmodule

// File: rtl/flash_alias_window.sv
module flash_alias_window
    import flash_alias_pkg::*;
#(
    parameter int         ADDR_W     = 32,
    parameter int         WIN_TAG_W  = 5,
    parameter logic [4:0] WIN_TAG    = 5'h01,
    parameter int         FLASH_AW   = 24,
    parameter logic [7:0] RD_OPCODE  = 8'h03,
    parameter int         DATA_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [ADDR_W-1:0]       bus_addr,
    output logic                    bus_ready,
    output logic [8*DATA_BYTES-1:0] bus_rdata,
    output logic                    bus_err,
    input  logic                    eng_req,
    output logic                    eng_gnt,
    input  logic                    eng_sck,
    input  logic                    eng_cs_n,
    input  logic                    eng_mosi,
    output logic                    spi_sck,
    output logic                    spi_cs_n,
    output logic                    spi_mosi,
    input  logic                    spi_miso
);
    localparam int DATA_W = 8 * DATA_BYTES;
    localparam int CMD_W  = 8 + FLASH_AW;

    typedef struct packed {
        logic                pend;
        logic [FLASH_AW-1:0] addr;
        logic [DATA_W-1:0]   rdata;
        logic                err;
    } hst_t;

    hst_t q, d;

    logic                rd_hit;
    logic [FLASH_AW-1:0] dec_addr;
    owner_e              owner;
    logic                sh_start, sh_busy, sh_done;
    logic                sh_sck, sh_cs_n, sh_mosi;
    logic [DATA_W-1:0]   sh_rx, swapped;

    flash_alias_decode #(
        .ADDR_W(ADDR_W), .WIN_TAG_W(WIN_TAG_W), .WIN_TAG(WIN_TAG), .FLASH_AW(FLASH_AW)
    ) u_dec (
        .addr(bus_addr), .write(bus_write), .rd_hit(rd_hit), .flash_addr(dec_addr)
    );

    flash_alias_arb u_arb (
        .clk(clk), .rst_n(rst_n), .eng_req(eng_req),
        .alias_req(q.pend), .alias_done(sh_done), .owner(owner)
    );

    assign sh_start = q.pend && (owner == OWN_ALIAS) && !sh_busy && !sh_done;

    flash_alias_shift #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .cmd({RD_OPCODE, q.addr}),
        .miso(spi_miso), .sck(sh_sck), .cs_n(sh_cs_n), .mosi(sh_mosi),
        .busy(sh_busy), .done(sh_done), .rx(sh_rx)
    );

    // first received byte goes to the least significant lane
    for (genvar b = 0; b < DATA_BYTES; b++) begin : g_swap
        assign swapped[8*b +: 8] = sh_rx[8*(DATA_BYTES-1-b) +: 8];
    end

    always_comb begin
        d     = q;
        d.err = 1'b0;
        if (!q.pend && bus_valid) begin
            if (rd_hit) begin
                d.pend = 1'b1;
                d.addr = dec_addr;
            end else begin
                d.err = 1'b1;
            end
        end
        if (q.pend && sh_done) begin
            d.pend  = 1'b0;
            d.rdata = swapped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_ready = ~q.pend;
    assign bus_rdata = q.rdata;
    assign bus_err   = q.err;
    assign eng_gnt   = (owner == OWN_ENG);

    always_comb begin
        if (owner == OWN_ENG) begin
            spi_sck  = eng_sck;
            spi_cs_n = eng_cs_n;
            spi_mosi = eng_mosi;
        end else begin
            spi_sck  = sh_sck;
            spi_cs_n = sh_cs_n;
            spi_mosi = sh_mosi;
        end
    end
endmodule

// File: rtl/flash_alias_window_chk.sv
module flash_alias_window_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_valid,
    input logic          bus_write,
    input logic          bus_ready,
    input logic          bus_err,
    input logic [DW-1:0] bus_rdata,
    input logic          eng_gnt,
    input logic          spi_sck,
    input logic          spi_cs_n,
    input logic          sh_busy,
    input logic          sh_done
);
    p_write_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && bus_write) |=> bus_err);

    p_err_not_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ready);

    p_ready_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ready) |-> $past(bus_valid));

    p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ready && !sh_done) |=> !bus_ready);

    p_rdata_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && $past(bus_ready)) |-> $stable(bus_rdata));

    p_sck_framed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && !eng_gnt) |-> !spi_cs_n);

    p_one_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_gnt && sh_busy));
endmodule

bind flash_alias_window flash_alias_window_chk #(.DW(DATA_W)) u_chk (.*);

// File: tb/flash_alias_window_test.sv
module flash_alias_window_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, bus_valid, bus_write, bus_ready, bus_err;
    logic [31:0] bus_addr, bus_rdata;
    logic        eng_req, eng_gnt, eng_sck, eng_cs_n, eng_mosi;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    flash_alias_window uut (.*);

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [31:0] last_word = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    function automatic logic [31:0] fword(input logic [23:0] a);
        return {fbyte(a + 24'd3), fbyte(a + 24'd2), fbyte(a + 24'd1), fbyte(a)};
    endfunction

    // flash model: 32 command bits in, then bytes out MSB first
    int          bitn = 0;
    int          pulses = 0;
    logic [31:0] cmd = '0;

    always @(negedge spi_cs_n) begin
        bitn = 0;
        cmd  = '0;
    end

    always @(posedge spi_sck) begin
        if (spi_cs_n === 1'b0) begin
            if (bitn < 32) cmd = {cmd[30:0], spi_mosi};
            bitn++;
            pulses++;
        end
    end

    always @(negedge spi_sck) begin
        if (spi_cs_n === 1'b0 && bitn >= 32 && bitn < 64) begin
            int k;
            logic [7:0] bt;
            k  = bitn - 32;
            bt = fbyte(cmd[23:0] + 24'(k / 8));
            spi_miso <= bt[7 - (k % 8)];
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic issue(input logic [31:0] a, input logic w);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_addr  = a;
        bus_write = w;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!bus_ready && n < 4000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_read(input logic [31:0] a, input string tag);
        int n;
        wait_ready(n);
        chk(n >= 128, "R7", {tag, " ready low span"}, n, 128);
        chk(cmd == {8'h03, a[23:0]}, "R4", {tag, " command frame"}, cmd, {8'h03, a[23:0]});
        chk(pulses == 64, "R5", {tag, " sck pulses"}, pulses, 64);
        chk(bus_rdata == fword(a[23:0]), "R6", {tag, " swapped word"}, bus_rdata, fword(a[23:0]));
        last_word = fword(a[23:0]);
    endtask

    // {address, write, expect error}
    localparam logic [33:0] VEC [0:5] = '{
        {32'h0800_0000, 1'b0, 1'b0},
        {32'h0812_3456, 1'b0, 1'b0},
        {32'h0FFF_FFFC, 1'b0, 1'b0},
        {32'h07FF_FFFC, 1'b0, 1'b1},
        {32'h1000_0000, 1'b0, 1'b1},
        {32'h0800_0010, 1'b1, 1'b1}
    };

    initial begin
        rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
        eng_req = 1'b0; eng_sck = 1'b0; eng_cs_n = 1'b1; eng_mosi = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(bus_ready == 1'b1, "R1", "ready in reset", bus_ready, 1);
        chk(bus_err == 1'b0, "R1", "err in reset", bus_err, 0);
        chk({spi_cs_n, spi_sck, spi_mosi} == 3'b100, "R1", "pins in reset",
            {spi_cs_n, spi_sck, spi_mosi}, 3'b100);
        chk(eng_gnt == 1'b0, "R1", "gnt in reset", eng_gnt, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 6; i++) begin
            logic [31:0] a;
            logic w, e;
            a = VEC[i][33:2];
            w = VEC[i][1];
            e = VEC[i][0];
            pulses = 0;
            cmd = '0;
            issue(a, w);
            if (e) begin
                chk(bus_err == 1'b1, w ? "R3" : "R2", "refused err", bus_err, 1);
                chk(bus_ready == 1'b1, w ? "R3" : "R2", "refused ready", bus_ready, 1);
                repeat (6) @(negedge clk);
                chk(pulses == 0, w ? "R3" : "R2", "no flash activity", pulses, 0);
                chk(bus_rdata == last_word, "R7", "rdata kept after refusal", bus_rdata, last_word);
            end else begin
                chk(bus_ready == 1'b0, "R7", "ready low after accept", bus_ready, 0);
                check_read(a, "table");
            end
        end

        // R7 hold of returned word
        repeat (8) @(negedge clk);
        chk(bus_rdata == last_word, "R7", "rdata held idle", bus_rdata, last_word);

        // R8 engine alone
        @(negedge clk);
        eng_req = 1'b1; eng_cs_n = 1'b0; eng_sck = 1'b1; eng_mosi = 1'b1;
        @(negedge clk);
        chk(eng_gnt == 1'b1, "R8", "grant when idle", eng_gnt, 1);
        chk({spi_cs_n, spi_sck, spi_mosi} == 3'b011, "R8", "engine pins",
            {spi_cs_n, spi_sck, spi_mosi}, 3'b011);
        eng_sck = 1'b0; eng_mosi = 1'b0; eng_cs_n = 1'b1; eng_req = 1'b0;
        @(negedge clk);
        chk(eng_gnt == 1'b0, "R8", "grant released", eng_gnt, 0);
        chk({spi_cs_n, spi_sck} == 2'b10, "R8", "pins idle after release",
            {spi_cs_n, spi_sck}, 2'b10);

        // R9 read waits for engine
        eng_req = 1'b1; eng_mosi = 1'b1;
        @(negedge clk);
        pulses = 0;
        issue(32'h0834_5678, 1'b0);
        repeat (20) @(negedge clk);
        chk(bus_ready == 1'b0, "R9", "read stalled by engine", bus_ready, 0);
        chk(pulses == 0, "R9", "no alias clocks under engine", pulses, 0);
        chk(spi_mosi == 1'b1, "R9", "engine still drives", spi_mosi, 1);
        eng_req = 1'b0; eng_mosi = 1'b0;
        check_read(32'h0834_5678, "after engine");

        // R9 engine waits for read
        begin
            int bad;
            int n;
            bad = 0;
            n = 0;
            pulses = 0;
            issue(32'h0800_ABC1, 1'b0);
            repeat (10) @(negedge clk);
            eng_req = 1'b1;
            while (!bus_ready && n < 4000) begin
                if (eng_gnt) bad++;
                @(negedge clk);
                n++;
            end
            chk(bad == 0, "R9", "no grant during read", bad, 0);
            chk(bus_rdata == fword(24'h00ABC1), "R6", "word with engine waiting",
                bus_rdata, fword(24'h00ABC1));
            last_word = fword(24'h00ABC1);
            @(negedge clk);
            chk(eng_gnt == 1'b1, "R9", "grant after read", eng_gnt, 1);
            eng_req = 1'b0;
            repeat (2) @(negedge clk);
        end

        // R10 tie: pending read and engine request seen together
        pulses = 0;
        issue(32'h0C00_0100, 1'b0);
        eng_req = 1'b1;
        @(negedge clk);
        chk(eng_gnt == 1'b1, "R10", "engine wins tie", eng_gnt, 1);
        chk(bus_ready == 1'b0, "R10", "read still pending", bus_ready, 0);
        repeat (5) @(negedge clk);
        chk(pulses == 0, "R10", "read held back", pulses, 0);
        eng_req = 1'b0;
        check_read(32'h0C00_0100, "after tie");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule